// File: doc/BRIEF.md
# Contrast PWM with Selectable Time Base

This block drives a display contrast line with a pulse-width-modulated signal. An 8-bit duty setting sets how many of every 256 counter steps the output stays high. The counter does not run on the system clock. It advances only on a one-cycle tick from one of three time bases: the display line pulse, the pixel clock enable or the peripheral clock enable. The time base is chosen at run time with a 2-bit selector.

All three ticks arrive as single-cycle strobes in the `clk` domain. When contrast control is switched off, the output is held low and the counter is parked at zero. A new duty value is applied at the next counter wrap, so the period in progress is never cut short or stretched.

Top module: `contrast_pwm`

## Requirements
- R1: After reset `pwm_out` is low and the period counter is 0.
- R2: The counter's time base follows `src_sel`: 0 selects `tick_line`, 1 selects `tick_pixel` and 2 selects `tick_periph`. The reserved code 3 behaves exactly like 0.
- R3: The counter advances by one only in a cycle where the selected tick is high. Ticks on the sources that are not selected have no effect.
- R4: While enabled, `pwm_out` is high exactly when the counter value is below the active duty, so one full period of 256 ticks gives `duty` high steps.
- R5: A duty of 0 gives a constant low output. A duty of 255 gives 255 high steps out of 256.
- R6: While `pwm_en` is low, `pwm_out` is low and the counter is forced to 0. After re-enabling, a period starts at count 0.
- R7: A duty value that changes while the block is enabled takes effect only after the counter wraps. While disabled, the active duty follows `duty` on every cycle.
- R8: The counter is 8 bits wide and wraps from 255 to 0 on a selected tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_line | input | 1 | Line pulse strobe, one cycle wide |
| tick_pixel | input | 1 | Pixel clock enable strobe |
| tick_periph | input | 1 | Peripheral clock enable strobe |
| src_sel | input | 2 | Time base select (0 line, 1 pixel, 2 peripheral, 3 as 0) |
| pwm_en | input | 1 | Contrast control enable |
| duty | input | 8 | Requested pulse width in counter steps |
| pwm_out | output | 1 | Contrast PWM output |

## Verification
A counter that steps on the wrong tick, or misses a step, moves the falling edge of `pwm_out`. The error is visible at the port within the same period, at the count where the duty is crossed. A shadow duty register that loads at the wrong moment changes the number of high steps in the period during which the duty was written. A counter that is not cleared when the block is disabled shows up as a missing high step at the very first tick after re-enabling. Each of these faults can therefore be caught within one period of 256 selected ticks.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  localparam int CPWM_CNT_W = 8;
  localparam int CPWM_SEL_W = 2;
  localparam int CPWM_N_SRC = 3;

  typedef enum logic [CPWM_SEL_W-1:0] {
    SRC_LINE   = 2'd0,
    SRC_PIXEL  = 2'd1,
    SRC_PERIPH = 2'd2,
    SRC_RSVD   = 2'd3
  } cpwm_src_e;

  // Map a select code to a source index; the reserved code aliases line.
  function automatic int unsigned cpwm_src_idx(input logic [CPWM_SEL_W-1:0] sel);
    case (cpwm_src_e'(sel))
      SRC_PIXEL:  cpwm_src_idx = 1;
      SRC_PERIPH: cpwm_src_idx = 2;
      default:    cpwm_src_idx = 0;
    endcase
  endfunction

  // Next counter value with natural wrap.
  function automatic logic [CPWM_CNT_W-1:0] cpwm_next(input logic [CPWM_CNT_W-1:0] c);
    cpwm_next = c + 1'b1;
  endfunction

  // Output level for a counter value against a duty.
  function automatic logic cpwm_level(input logic [CPWM_CNT_W-1:0] c,
                                      input logic [CPWM_CNT_W-1:0] d);
    cpwm_level = (c < d);
  endfunction

endpackage

// File: rtl/cpwm_tick_mux.sv
module cpwm_tick_mux
  import cpwm_pkg::*;
#(
  parameter int N_SRC = CPWM_N_SRC,
  parameter int SEL_W = CPWM_SEL_W
) (
  input  logic [N_SRC-1:0] ticks,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  int unsigned idx;

  always_comb begin
    idx  = cpwm_src_idx(sel);
    tick = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (idx == i) tick = ticks[i];
    end
  end

endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int CNT_W = CPWM_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  assign wrap = en & tick & (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (tick)   cnt <= cpwm_next(cnt);
  end

endmodule

// File: rtl/cpwm_duty_shadow.sv
module cpwm_duty_shadow #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             wrap,
  input  logic [CNT_W-1:0] duty_in,
  output logic [CNT_W-1:0] duty_act
);

  logic load;
  assign load = ~en | wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     duty_act <= '0;
    else if (load)  duty_act <= duty_in;
  end

endmodule

// File: rtl/contrast_pwm.sv
module contrast_pwm
  import cpwm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_line,
  input  logic                  tick_pixel,
  input  logic                  tick_periph,
  input  logic [CPWM_SEL_W-1:0] src_sel,
  input  logic                  pwm_en,
  input  logic [CPWM_CNT_W-1:0] duty,
  output logic                  pwm_out
);

  logic [CPWM_N_SRC-1:0] tick_vec;
  logic                  sel_tick;
  logic [CPWM_CNT_W-1:0] cnt_q;
  logic                  wrap_evt;
  logic [CPWM_CNT_W-1:0] duty_act;

  assign tick_vec = {tick_periph, tick_pixel, tick_line};

  cpwm_tick_mux #(.N_SRC(CPWM_N_SRC), .SEL_W(CPWM_SEL_W)) u_mux (
    .ticks (tick_vec),
    .sel   (src_sel),
    .tick  (sel_tick)
  );

  cpwm_counter #(.CNT_W(CPWM_CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (pwm_en),
    .tick  (sel_tick),
    .cnt   (cnt_q),
    .wrap  (wrap_evt)
  );

  cpwm_duty_shadow #(.CNT_W(CPWM_CNT_W)) u_duty (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (pwm_en),
    .wrap     (wrap_evt),
    .duty_in  (duty),
    .duty_act (duty_act)
  );

  assign pwm_out = pwm_en & cpwm_level(cnt_q, duty_act);

endmodule

// File: rtl/contrast_pwm_chk.sv
module contrast_pwm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_pixel,
  input logic [1:0] src_sel,
  input logic       pwm_en,
  input logic       pwm_out,
  input logic       sel_tick,
  input logic       wrap_evt,
  input logic [7:0] cnt_q,
  input logic [7:0] duty_act
);

  p_hold_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en |=> (cnt_q == 8'd0));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !sel_tick) |=> $stable(cnt_q));

  p_step_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && sel_tick) |=> (cnt_q == 8'($past(cnt_q) + 8'd1)));

  p_duty_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && !wrap_evt) |=> $stable(duty_act));

  p_zero_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_act == 8'd0) |-> !pwm_out);

  p_pixel_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_en && src_sel == 2'd1 && !tick_pixel) |=> $stable(cnt_q));

endmodule

bind contrast_pwm contrast_pwm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_pixel (tick_pixel),
  .src_sel    (src_sel),
  .pwm_en     (pwm_en),
  .pwm_out    (pwm_out),
  .sel_tick   (sel_tick),
  .wrap_evt   (wrap_evt),
  .cnt_q      (cnt_q),
  .duty_act   (duty_act)
);

// File: tb/test_contrast_pwm.sv
`timescale 1ns/1ps
module test_contrast_pwm;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_line = 1'b0, tick_pixel = 1'b0, tick_periph = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic       pwm_en = 1'b0;
  logic [7:0] duty = 8'd0;
  logic       pwm_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  contrast_pwm i_contrast_pwm (
    .clk(clk), .rst_n(rst_n), .tick_line(tick_line), .tick_pixel(tick_pixel),
    .tick_periph(tick_periph), .src_sel(src_sel), .pwm_en(pwm_en),
    .duty(duty), .pwm_out(pwm_out)
  );

  // {src_sel, duty, expected high steps per period}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'd0,   8'd0},
    {2'd0, 8'd255, 8'd255},
    {2'd1, 8'd100, 8'd100},
    {2'd2, 8'd37,  8'd37},
    {2'd3, 8'd200, 8'd200},
    {2'd1, 8'd1,   8'd1},
    {2'd2, 8'd128, 8'd128},
    {2'd0, 8'd64,  8'd64}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse one source for a single cycle; 0 line, 1 pixel, 2 peripheral.
  task automatic pulse(input int src);
    @(negedge clk);
    tick_line   = (src == 0);
    tick_pixel  = (src == 1);
    tick_periph = (src == 2);
    @(negedge clk);
    tick_line = 1'b0; tick_pixel = 1'b0; tick_periph = 1'b0;
    #1;
  endtask

  task automatic restart(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    pwm_en = 1'b0; src_sel = s; duty = d;
    @(negedge clk);
    @(negedge clk);
    pwm_en = 1'b1;
    #1;
  endtask

  // Count high samples over n selected ticks, with stray ticks between.
  task automatic run_ticks(input int src, input int n, input bit stray, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      if (pwm_out) highs++;
      if (stray) pulse((src + 1) % 3);
      pulse(src);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int h;
    int src;
    #1;
    check("R1 output after reset", int'(pwm_out), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 output after release", int'(pwm_out), 0);

    // Table: select codes, duty values, stray ticks on other sources (R2 R3 R4 R5)
    for (int v = 0; v < NV; v++) begin
      restart(VEC[v][17:16], VEC[v][15:8]);
      src = (VEC[v][17:16] == 2'd3) ? 0 : int'(VEC[v][17:16]);
      run_ticks(src, 256, 1'b1, h);
      check($sformatf("R2 R3 R4 R5 vector %0d high steps", v), h, int'(VEC[v][7:0]));
    end

    // R8: after a full period the counter wrapped back to 0 -> high with duty 1
    restart(2'd1, 8'd1);
    run_ticks(1, 256, 1'b0, h);
    check("R8 wrap to zero", int'(pwm_out), 1);
    pulse(1);
    check("R8 count one after wrap", int'(pwm_out), 0);

    // R6: disabled with full duty stays low despite ticks
    @(negedge clk);
    pwm_en = 1'b0; duty = 8'd255; src_sel = 2'd0;
    #1;
    check("R6 low when disabled", int'(pwm_out), 0);
    pulse(0); pulse(0); pulse(1); pulse(2);
    check("R6 low after ticks while disabled", int'(pwm_out), 0);

    // R6: disabling mid-period returns the counter to 0
    restart(2'd0, 8'd128);
    run_ticks(0, 200, 1'b0, h);
    check("R6 low past duty", int'(pwm_out), 0);
    @(negedge clk); pwm_en = 1'b0;
    @(negedge clk); pwm_en = 1'b1;
    #1;
    check("R6 high at restart from zero", int'(pwm_out), 1);
    run_ticks(0, 256, 1'b0, h);
    check("R6 full period after restart", h, 128);

    // R7: duty change mid-period waits for the wrap
    restart(2'd2, 8'd10);
    run_ticks(2, 5, 1'b0, h);
    @(negedge clk); duty = 8'd200; #1;
    run_ticks(2, 251, 1'b0, h);
    check("R7 old duty kept until wrap", h, 5);
    run_ticks(2, 256, 1'b0, h);
    check("R7 new duty after wrap", h, 200);

    // R7: while disabled the active duty follows the input immediately
    @(negedge clk); pwm_en = 1'b0; duty = 8'd3;
    @(negedge clk); duty = 8'd0;
    @(negedge clk); pwm_en = 1'b1; #1;
    check("R7 R5 duty zero taken while disabled", int'(pwm_out), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule